// File: doc/BRIEF.md
# TLB Maintenance Register Block

This block holds the three control registers that software uses to maintain a translation lookaside buffer: a page-table pointer register that carries the virtual page number (VPN) used as an index, a control register that carries the address-space identifier (PID), the way selector, a read trigger and a write enable, and an entry register that carries the physical frame number (PFN), the cache, read, write and execute permission bits and the global bit. Software writes the registers over a plain strobe-and-select bus and reads them back through a combinational read mux on the same select.

The block drives the TLB's single entry port. Reads are combinational, and writes take effect at the clock edge. Writing the entry register while the write enable is set commits an entry and steps the way selector. Writing the control register with the read trigger set loads an entry back into all three registers. Whenever the block drops a live translation it raises a one-cycle invalidate request with that page's address. This happens when a valid entry is overwritten with different contents, and when the PID changes. On a PID change the block walks every entry, one per clock. During the walk it holds `busy` high and refuses bus writes.

Top module: `tlbm_regs`

## Requirements
- R1: After reset all three registers read 0. `busy`, `tlb_we` and `inv_valid` are low and `reg_ready` is high. A write with select 3 changes no register, and select 3 reads 0.
- R2: A write to the entry register (select 2) while control bit 18 (write enable) is set drives `tlb_we` in the same cycle. The index is {way field bits 23:20 reduced to the way count, low set bits of the last written VPN}. The tag is {VPN[19:0], global = written bit 24, valid, last written PID}. The data is written bits 23:0: C at 23, R at 22, W at 21, X at 20 and PFN at 19:0.
- R3: The valid bit of a committed tag is 1 exactly when the VPN is below 0xC0000.
- R4: Each entry commit advances the way field by one, modulo the number of ways. An entry-register write while bit 18 is clear commits nothing and leaves the way field alone.
- R5: When a commit replaces a valid entry with a different tag or different data, `inv_valid` pulses in the next cycle with `inv_addr` = old VPN << 12. Identical rewrites and overwrites of invalid entries raise no request.
- R6: A write to the control register (select 1) with bit 19 set reads the entry at {written way field, set bits of the last written VPN}. The entry's data and global bit go into entry-register bits 24:0, its PID goes into control bits 4 and up, and its VPN goes into pointer bits 21:2.
- R7: A write to the pointer register (select 0) updates every readable bit except the VPN field at bits 21:2. The written VPN (value >> 2) is kept privately and used for all later indexing.
- R8: A control write whose PID field differs from the last written PID starts a walk over all entries. Each entry that is valid, non-global and tagged with the old PID yields one `inv_valid` pulse carrying its page address.
- R9: `busy` stays high for exactly one cycle per TLB entry, and `reg_ready` is low during that time. Writes presented while busy are dropped and no entry is written.
- R10: A write to the entry register never changes its readable value. Only a read-back loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 control, 2 entry |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readable copy of the selected register |
| reg_ready | output | 1 | High when a write will be accepted |
| busy | output | 1 | PID flush walk in progress |
| tlb_idx | output | IDX_W | TLB entry index for read and write |
| tlb_rtag | input | TAG_W | Tag read at `tlb_idx` (combinational) |
| tlb_rdata | input | 24 | Data read at `tlb_idx` (combinational) |
| tlb_we | output | 1 | TLB entry write enable |
| tlb_wtag | output | TAG_W | Tag to write |
| tlb_wdata | output | 24 | Data to write |
| inv_valid | output | 1 | One-cycle invalidate request |
| inv_addr | output | 32 | Page address to invalidate |

## Verification
The assertions assume that the TLB array returns the entry at `tlb_idx` combinationally, in the same cycle, and that a written entry is visible from the following cycle. The bench's array model behaves exactly this way. The checks also assume that the bus source respects `reg_ready` except in the one directed case that tests the stall. In that case the bench drives a strobe during the walk deliberately, and afterwards the registers must show no trace of it. All other writes wait for `reg_ready` and leave an idle cycle between them. As a result, an invalidate request can be traced to a commit or a walk step one cycle earlier.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int REG_W       = 32;
    localparam int VPN_W       = 20;
    localparam int PFN_W       = 20;
    localparam int PAGE_SHIFT  = 12;

    localparam logic [1:0] SEL_PTR  = 2'd0;
    localparam logic [1:0] SEL_CTL  = 2'd1;
    localparam logic [1:0] SEL_ENT  = 2'd2;

    localparam int PTR_VPN_LSB  = 2;
    localparam int CTL_PID_LSB  = 4;
    localparam int CTL_WE_BIT   = 18;
    localparam int CTL_RD_BIT   = 19;
    localparam int CTL_WAY_LSB  = 20;
    localparam int CTL_WAY_W    = 4;
    localparam int ENT_G_BIT    = 24;

    localparam logic [VPN_W-1:0] VPN_VALID_LIMIT = 20'hC0000;

    typedef struct packed {
        logic             c;
        logic             r;
        logic             w;
        logic             x;
        logic [PFN_W-1:0] pfn;
    } tlbm_data_t;

    localparam int DATA_W = $bits(tlbm_data_t);

endpackage

// File: rtl/tlbm_entry_build.sv
module tlbm_entry_build
    import tlbm_pkg::*;
#(
    parameter int PID_W = 8,
    localparam int TAG_W = VPN_W + 2 + PID_W
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [PID_W-1:0]  pid,
    input  logic [ENT_G_BIT:0] ent_word,
    input  logic [TAG_W-1:0]  old_tag,
    input  logic [DATA_W-1:0] old_data,
    output logic [TAG_W-1:0]  new_tag,
    output logic [DATA_W-1:0] new_data,
    output logic              replace_inv,
    output logic [REG_W-1:0]  old_page
);

    logic valid_new;
    logic old_valid;

    always_comb begin
        valid_new   = (vpn < VPN_VALID_LIMIT);
        new_tag     = {vpn, ent_word[ENT_G_BIT], valid_new, pid};
        new_data    = ent_word[DATA_W-1:0];
        old_valid   = old_tag[PID_W];
        replace_inv = old_valid && ((old_tag != new_tag) || (old_data != new_data));
        old_page    = {old_tag[TAG_W-1 -: VPN_W], {PAGE_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/tlbm_pid_walker.sv
module tlbm_pid_walker
    import tlbm_pkg::*;
#(
    parameter int PID_W   = 8,
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = VPN_W + 2 + PID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PID_W-1:0] old_pid,
    input  logic [TAG_W-1:0] rtag,
    output logic             busy,
    output logic [IDX_W-1:0] walk_idx,
    output logic             hit
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [PID_W-1:0] pid;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        if (walk_q.busy) begin
            if (walk_q.idx == LAST_IDX) begin
                walk_d.busy = 1'b0;
            end else begin
                walk_d.idx = walk_q.idx + 1'b1;
            end
        end else if (start) begin
            walk_d.busy = 1'b1;
            walk_d.idx  = '0;
            walk_d.pid  = old_pid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy     = walk_q.busy;
    assign walk_idx = walk_q.idx;
    assign hit      = walk_q.busy && rtag[PID_W] && !rtag[PID_W+1]
                      && (rtag[PID_W-1:0] == walk_q.pid);

endmodule

// File: rtl/tlbm_regs.sv
module tlbm_regs
    import tlbm_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int PID_W = 8,
    localparam int ENTRIES = WAYS * SETS,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int SET_W   = $clog2(SETS),
    localparam int IDX_W   = WAY_W + SET_W,
    localparam int TAG_W   = VPN_W + 2 + PID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_ready,
    output logic              busy,
    output logic [IDX_W-1:0]  tlb_idx,
    input  logic [TAG_W-1:0]  tlb_rtag,
    input  logic [DATA_W-1:0] tlb_rdata,
    output logic              tlb_we,
    output logic [TAG_W-1:0]  tlb_wtag,
    output logic [DATA_W-1:0] tlb_wdata,
    output logic              inv_valid,
    output logic [REG_W-1:0]  inv_addr
);

    typedef struct packed {
        logic [REG_W-1:0] ptr;
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] ent;
        logic [VPN_W-1:0] vpn_wr;
        logic [PID_W-1:0] pid_wr;
        logic             inv_v;
        logic [REG_W-1:0] inv_a;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             walk_busy;
    logic [IDX_W-1:0] walk_idx;
    logic             walk_hit;
    logic             walk_start;
    logic [TAG_W-1:0] new_tag;
    logic [DATA_W-1:0] new_data;
    logic             replace_inv;
    logic [REG_W-1:0] old_page;
    logic             wr_ok;
    logic [WAY_W-1:0] cur_way;
    logic [WAY_W-1:0] next_way;
    logic [PID_W-1:0] wr_pid_field;

    assign wr_ok        = reg_wr && !walk_busy;
    assign cur_way      = regs_q.ctl[CTL_WAY_LSB +: WAY_W];
    assign next_way     = cur_way + 1'b1;
    assign wr_pid_field = reg_wdata[CTL_PID_LSB +: PID_W];

    tlbm_entry_build #(
        .PID_W (PID_W)
    ) u_build (
        .vpn         (regs_q.vpn_wr),
        .pid         (regs_q.pid_wr),
        .ent_word    (reg_wdata[ENT_G_BIT:0]),
        .old_tag     (tlb_rtag),
        .old_data    (tlb_rdata),
        .new_tag     (new_tag),
        .new_data    (new_data),
        .replace_inv (replace_inv),
        .old_page    (old_page)
    );

    tlbm_pid_walker #(
        .PID_W   (PID_W),
        .ENTRIES (ENTRIES)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (walk_start),
        .old_pid  (regs_q.pid_wr),
        .rtag     (tlb_rtag),
        .busy     (walk_busy),
        .walk_idx (walk_idx),
        .hit      (walk_hit)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.inv_v = 1'b0;
        walk_start   = 1'b0;
        tlb_we       = 1'b0;
        tlb_wtag     = new_tag;
        tlb_wdata    = new_data;
        tlb_idx      = {cur_way, regs_q.vpn_wr[SET_W-1:0]};

        if (walk_busy) begin
            tlb_idx = walk_idx;
        end else if (reg_wr && (reg_sel == SEL_CTL) && reg_wdata[CTL_RD_BIT]) begin
            tlb_idx = {reg_wdata[CTL_WAY_LSB +: WAY_W], regs_q.vpn_wr[SET_W-1:0]};
        end

        if (walk_hit) begin
            regs_d.inv_v = 1'b1;
            regs_d.inv_a = {tlb_rtag[TAG_W-1 -: VPN_W], {PAGE_SHIFT{1'b0}}};
        end

        if (wr_ok) begin
            case (reg_sel)
                SEL_PTR: begin
                    regs_d.ptr = reg_wdata;
                    regs_d.ptr[PTR_VPN_LSB +: VPN_W] = regs_q.ptr[PTR_VPN_LSB +: VPN_W];
                    regs_d.vpn_wr = reg_wdata[PTR_VPN_LSB +: VPN_W];
                end
                SEL_CTL: begin
                    regs_d.pid_wr = wr_pid_field;
                    walk_start    = (wr_pid_field != regs_q.pid_wr);
                    regs_d.ctl    = reg_wdata;
                    if (reg_wdata[CTL_RD_BIT]) begin
                        regs_d.ctl[CTL_PID_LSB +: PID_W] = tlb_rtag[PID_W-1:0];
                        regs_d.ent[ENT_G_BIT:0] = {tlb_rtag[PID_W+1], tlb_rdata};
                        regs_d.ptr[PTR_VPN_LSB +: VPN_W] = tlb_rtag[TAG_W-1 -: VPN_W];
                    end
                end
                SEL_ENT: begin
                    if (regs_q.ctl[CTL_WE_BIT]) begin
                        tlb_we = 1'b1;
                        regs_d.ctl[CTL_WAY_LSB +: CTL_WAY_W] = CTL_WAY_W'(next_way);
                        if (replace_inv) begin
                            regs_d.inv_v = 1'b1;
                            regs_d.inv_a = old_page;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_PTR: reg_rdata = regs_q.ptr;
            SEL_CTL: reg_rdata = regs_q.ctl;
            SEL_ENT: reg_rdata = regs_q.ent;
            default: reg_rdata = '0;
        endcase
    end

    assign reg_ready = !walk_busy;
    assign busy      = walk_busy;
    assign inv_valid = regs_q.inv_v;
    assign inv_addr  = regs_q.inv_a;

endmodule

module tlbm_regs_chk
    import tlbm_pkg::*;
#(
    parameter int PID_W = 8,
    localparam int TAG_W = VPN_W + 2 + PID_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_sel,
    input logic             busy,
    input logic             tlb_we,
    input logic [TAG_W-1:0] tlb_wtag,
    input logic             inv_valid,
    input logic [REG_W-1:0] inv_addr
);

    assert_no_commit_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tlb_we);

    assert_walk_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && (reg_sel == SEL_CTL)));

    assert_inv_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ($past(tlb_we) || $past(busy)));

    assert_valid_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_we |-> (tlb_wtag[PID_W] == (tlb_wtag[TAG_W-1 -: VPN_W] < VPN_VALID_LIMIT)));

    assert_page_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_addr[PAGE_SHIFT-1:0] == '0));

endmodule

bind tlbm_regs tlbm_regs_chk #(
    .PID_W (PID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .busy      (busy),
    .tlb_we    (tlb_we),
    .tlb_wtag  (tlb_wtag),
    .inv_valid (inv_valid),
    .inv_addr  (inv_addr)
);

// File: tb/tb_tlbm_regs.sv
`timescale 1ns/1ps
module tb_tlbm_regs;
    import tlbm_pkg::*;

    localparam int WAYS = 4, SETS = 16, PID_W = 8;
    localparam int ENTRIES = WAYS * SETS;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = VPN_W + 2 + PID_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata, inv_addr;
    logic reg_ready, busy, tlb_we, inv_valid;
    logic [IDX_W-1:0] tlb_idx;
    logic [TAG_W-1:0] tlb_rtag, tlb_wtag;
    logic [DATA_W-1:0] tlb_rdata, tlb_wdata;

    logic [TAG_W-1:0]  mtag  [ENTRIES];
    logic [DATA_W-1:0] mdata [ENTRIES];

    int checks = 0, fails = 0, inv_cnt = 0, busy_n = 0;
    logic [31:0] inv_last = '0;
    logic cap_we, cap_inv;
    logic [IDX_W-1:0] cap_idx;
    logic [TAG_W-1:0] cap_tag;
    logic [DATA_W-1:0] cap_data;
    logic [31:0] cap_inv_addr;

    always #4 clk = ~clk;

    tlbm_regs #(.WAYS(WAYS), .SETS(SETS), .PID_W(PID_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .busy(busy), .tlb_idx(tlb_idx), .tlb_rtag(tlb_rtag), .tlb_rdata(tlb_rdata),
        .tlb_we(tlb_we), .tlb_wtag(tlb_wtag), .tlb_wdata(tlb_wdata),
        .inv_valid(inv_valid), .inv_addr(inv_addr));

    // TLB array model: combinational read, write at the edge
    assign tlb_rtag  = mtag[tlb_idx];
    assign tlb_rdata = mdata[tlb_idx];
    initial for (int i = 0; i < ENTRIES; i++) begin mtag[i] = '0; mdata[i] = '0; end
    always @(posedge clk) if (tlb_we) begin mtag[tlb_idx] <= tlb_wtag; mdata[tlb_idx] <= tlb_wdata; end

    always @(negedge clk) if (inv_valid) begin inv_cnt++; inv_last = inv_addr; end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        while (!reg_ready) @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        #1;
        cap_we = tlb_we; cap_idx = tlb_idx; cap_tag = tlb_wtag; cap_data = tlb_wdata;
        @(negedge clk);
        reg_wr = 1'b0;
        cap_inv = inv_valid; cap_inv_addr = inv_addr;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    // {write select, write data, read select, expected read value}
    localparam logic [67:0] VEC [8] = '{
        {2'd0, 32'h00C00049, 2'd0, 32'h00C00001},  // R7 VPN field not updated
        {2'd1, 32'h00140050, 2'd1, 32'h00140050},  // ctl write, pid 0->5
        {2'd2, 32'h00E00ABC, 2'd1, 32'h00240050},  // R4 commit idx 18, way 1->2
        {2'd2, 32'h01100ABC, 2'd2, 32'h00000000},  // R10 commit idx 34, entry reg unchanged
        {2'd1, 32'h00180050, 2'd2, 32'h00E00ABC},  // R6 read back idx 18
        {2'd1, 32'h00280050, 2'd2, 32'h01100ABC},  // R6 read back idx 34, global
        {2'd0, 32'h00000000, 2'd0, 32'h00000048},  // R6 VPN loaded by read back
        {2'd2, 32'hFFFFFFFF, 2'd0, 32'h00000048}   // placeholder replaced below
    };

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, v); check("R1 ptr", 64'(v), 64'h0);
        rd(2'd1, v); check("R1 ctl", 64'(v), 64'h0);
        rd(2'd2, v); check("R1 ent", 64'(v), 64'h0);
        check("R1 idle", {busy, reg_ready, tlb_we, inv_valid}, 64'b0100);
        rst_n = 1'b1;

        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][67:66], VEC[i][65:34]);
            rd(VEC[i][33:32], v);
            check($sformatf("vector %0d", i), 64'(v), 64'(VEC[i][31:0]));
        end

        // R1 select 3 is ignored and reads 0
        wr(2'd3, 32'hFFFFFFFF);
        rd(2'd0, v); check("R1 sel3 no effect", 64'(v), 64'h48);
        rd(2'd3, v); check("R1 sel3 reads 0", 64'(v), 64'h0);

        // R2/R3: commit above the valid limit, into an invalid slot
        wr(2'd0, 32'h00300004);
        wr(2'd1, 32'h00040050);
        wr(2'd2, 32'h00200001);
        check("R2 we", 64'(cap_we), 64'h1);
        check("R2 idx", 64'(cap_idx), 64'd1);
        check("R3 tag invalid", 64'(cap_tag), 64'({20'hC0001, 1'b0, 1'b0, 8'h05}));
        check("R2 data", 64'(cap_data), 64'h200001);
        check("R5 no inv on invalid old", 64'(cap_inv), 64'h0);
        rd(2'd1, v); check("R4 way 0->1", 64'(v), 64'h00140050);

        // R5: replace valid entry 18, then identical rewrite
        wr(2'd0, 32'h00000048);
        wr(2'd2, 32'h00400005);
        check("R3 tag valid", 64'(cap_tag), 64'({20'h00012, 1'b0, 1'b1, 8'h05}));
        check("R5 inv pulse", {cap_inv, cap_inv_addr}, {1'b1, 32'h00012000});
        wr(2'd1, 32'h00140050);
        wr(2'd2, 32'h00400005);
        check("R5 no inv same entry", 64'(cap_inv), 64'h0);

        // R4: no write enable
        wr(2'd1, 32'h00100050);
        wr(2'd2, 32'h00400007);
        check("R4 no commit", 64'(cap_we), 64'h0);
        rd(2'd1, v); check("R4 way kept", 64'(v), 64'h00100050);

        // R4: wrap from last way, idx 50
        wr(2'd1, 32'h00340050);
        wr(2'd2, 32'h00400003);
        check("R2 idx way 3", 64'(cap_idx), 64'd50);
        rd(2'd1, v); check("R4 way wraps", 64'(v), 64'h00040050);

        // R8/R9: PID change 5->7 flushes entries 18 and 50 only
        inv_cnt = 0;
        wr(2'd1, 32'h00000070);
        check("R9 ready low", {busy, reg_ready}, 64'b10);
        busy_n = 0;
        for (int k = 0; k < 100; k++) begin
            if (k == 0) begin reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'hFFFFFFFF; end
            if (k == 1) reg_wr = 1'b0;
            if (busy) busy_n++;
            @(negedge clk);
        end
        check("R9 busy length", 64'(busy_n), 64'(ENTRIES));
        check("R8 inv count", 64'(inv_cnt), 64'd2);
        check("R8 inv addr", 64'(inv_last), 64'h00012000);
        rd(2'd0, v); check("R9 stalled write dropped", 64'(v), 64'h48);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule